// File: doc/BRIEF.md
# Bus Address Decoder with Write Routing

This block sits between a single bus master and the targets of a 24-bit byte-addressed space. Each cycle the master may present one access: a byte write, a byte read or a 16-bit word read. The block decodes the address into one of six target regions and raises a one-hot select for that region, with the requester tag passed unchanged beside it. The six regions are main RAM, cartridge ROM, a small optical-drive register window, boot ROM, a video register region and an audio register region. Writes to read-only or unmapped space are dropped. Reads are answered one clock later with the tag of the request.

The writable storage is held inside the block as small byte arrays. Main RAM and the scratch parts of the three register regions repeat across their windows, at a depth set by parameters. ROM regions return a fixed pattern computed from the address. Three pieces of behaviour inside the register regions matter to software:

- The colour-lookup window holds two palette banks that are kept identical.
- Two 16-bit timer registers are built from byte writes, and each such write raises a reload strobe.
- A wavetable window inside the audio region cannot be written.

Top module: `sbd_bus_decoder`

## Requirements
- R1: Only acc_addr[23:0] is decoded. Bits above 23 have no effect on selects, writes or read data.
- R2: tgt_sel is one-hot while acc_valid is high: bit0 RAM 0x000000–0x3FFFFF, bit1 cartridge ROM 0x800000–0xDFFEFF, bit2 optical window 0xDFFF00–0xDFFFFF, bit3 boot ROM 0xE00000–0xE3FFFF, bit4 video 0xF00000–0xF0FFFF, bit5 audio 0xF10000–0xF1FFFF. It is all-zero for any other address and whenever acc_valid is low.
- R3: Byte writes to RAM, to the optical window, and to the scratch part of the video and audio regions are read back unchanged. RAM repeats every 2^RAM_AW bytes, the optical window every 256 bytes, and the video and audio scratch every 2^VID_AW and 2^AUD_AW bytes. Writes are always one byte (acc_wdata) whatever acc_word says.
- R4: Writes to cartridge ROM and boot ROM are discarded. A cartridge read returns addr[7:0] XOR 0xC3 and a boot ROM read returns addr[7:0] XOR 0x5A.
- R5: Writes to unmapped space (0x400000–0x7FFFFF, 0xE40000–0xEFFFFF, 0xF20000 and above) are discarded, and reads there return zero.
- R6: One clock after a read, rd_valid is high and rd_tag equals the request tag. A byte read returns the byte in rd_data[7:0] with rd_data[15:8] zero. rd_valid is low in the clock after a write or an idle cycle.
- R7: A word read ignores address bit 0 and returns the even byte in rd_data[15:8] and the odd byte in rd_data[7:0].
- R8: A byte write anywhere in 0xF00400–0xF007FF stores the byte at offset addr[8:0] in both bank A (0xF00400–0xF005FF) and bank B (0xF00600–0xF007FF).
- R9: Byte writes to 0xF00050/0xF00051 set the high and low byte of tmr_prescale. Byte writes to 0xF00052/0xF00053 set the high and low byte of tmr_divide. Reads of these addresses return the same bytes. No other write changes either register.
- R10: tmr_reload is high for exactly the one clock that follows each byte write to 0xF00050–0xF00053, and low otherwise.
- R11: Writes to the wavetable window 0xF1D000–0xF1DFFF are ignored. Reads there return addr[7:0] XOR 0x96.
- R12: tgt_tag equals acc_tag while acc_valid is high and is zero otherwise.
- R13: After reset, rd_valid, rd_data, rd_tag, tmr_prescale, tmr_divide and tmr_reload are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = byte write, 0 = read |
| acc_word | input | 1 | Read width: 1 = 16-bit word, 0 = byte |
| acc_addr | input | IN_AW | Byte address; only bits 23:0 are decoded |
| acc_wdata | input | 8 | Write byte |
| acc_tag | input | TAG_W | Requester tag |
| tgt_sel | output | 6 | One-hot region select |
| tgt_tag | output | TAG_W | Tag forwarded with the select |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 16 | Read response data |
| rd_tag | output | TAG_W | Tag of the answered read |
| tmr_prescale | output | 16 | Timer prescaler register |
| tmr_divide | output | 16 | Timer divider register |
| tmr_reload | output | 1 | One-clock timer reload strobe |

## Verification
A decode fault shows at tgt_sel in the same cycle as the access, and a lost or misrouted write shows in rd_data on the first later read of that byte, one clock after that read is issued. A palette bank that falls out of step appears only when the other bank's offset is read, so the bench reads the banks crosswise. A timer byte in the wrong lane, or a missing or stretched reload strobe, shows on the timer outputs in the clock right after the write.

// File: rtl/sbd_pkg.sv
package sbd_pkg;

   localparam int ADDR_W   = 24;
   localparam int N_REGION = 6;
   localparam int PAL_AW   = 9;
   localparam int OPT_AW   = 8;
   localparam int TMR_W    = 16;
   localparam int RSP_W    = 16;

   typedef enum logic [2:0] {
      RG_RAM  = 3'd0,
      RG_CART = 3'd1,
      RG_OPT  = 3'd2,
      RG_BOOT = 3'd3,
      RG_VID  = 3'd4,
      RG_AUD  = 3'd5,
      RG_NONE = 3'd6
   } region_e;

   localparam logic [7:0] CART_KEY = 8'hC3;
   localparam logic [7:0] BOOT_KEY = 8'h5A;
   localparam logic [7:0] WAVE_KEY = 8'h96;

   function automatic region_e region_of(input logic [ADDR_W-1:0] a);
      region_e r;
      if (a <= 24'h3FFFFF)      r = RG_RAM;
      else if (a < 24'h800000)  r = RG_NONE;
      else if (a <= 24'hDFFEFF) r = RG_CART;
      else if (a <= 24'hDFFFFF) r = RG_OPT;
      else if (a <= 24'hE3FFFF) r = RG_BOOT;
      else if (a < 24'hF00000)  r = RG_NONE;
      else if (a <= 24'hF0FFFF) r = RG_VID;
      else if (a <= 24'hF1FFFF) r = RG_AUD;
      else                      r = RG_NONE;
      return r;
   endfunction

   // palette window: bit 10 set, bit 11 clear, inside the video page
   function automatic logic is_pal(input logic [ADDR_W-1:0] a);
      return a[23:10] == 14'h3C01;
   endfunction

   // four timer bytes starting at 0xF00050
   function automatic logic is_tmr(input logic [ADDR_W-1:0] a);
      return a[23:2] == 22'h3C0014;
   endfunction

   function automatic logic is_wave(input logic [ADDR_W-1:0] a);
      return a[23:12] == 12'hF1D;
   endfunction

endpackage

// File: rtl/sbd_region_decode.sv
module sbd_region_decode
   import sbd_pkg::*;
#(
   parameter int NREG = N_REGION
) (
   input  logic              valid,
   input  logic [ADDR_W-1:0] addr,
   output logic [NREG-1:0]   sel,
   output logic              pal_hit,
   output logic              tmr_hit,
   output logic              wave_hit
);

   if (NREG != N_REGION) begin : g_bad_nreg
      $error("sbd_region_decode: NREG must equal the region count");
   end

   region_e    rg;
   logic [2:0] rg_code;

   assign rg      = region_of(addr);
   assign rg_code = rg;

   for (genvar i = 0; i < NREG; i++) begin : g_sel
      assign sel[i] = valid && (rg_code == 3'(i));
   end

   assign pal_hit  = valid && is_pal(addr);
   assign tmr_hit  = valid && is_tmr(addr);
   assign wave_hit = valid && is_wave(addr);

endmodule

// File: rtl/sbd_byte_store.sv
module sbd_byte_store #(
   parameter int AW = 8,
   parameter int RP = 2
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [7:0]       wdata,
   input  logic [RP*AW-1:0] raddr,
   output logic [RP*8-1:0]  rdata
);

   localparam int DEPTH = 1 << AW;

   if (AW < 1 || AW > 12) begin : g_bad_aw
      $error("sbd_byte_store: AW out of range 1..12");
   end
   if (RP < 1) begin : g_bad_rp
      $error("sbd_byte_store: RP must be at least 1");
   end

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   for (genvar p = 0; p < RP; p++) begin : g_rd
      assign rdata[p*8 +: 8] = mem[raddr[p*AW +: AW]];
   end

endmodule

// File: rtl/sbd_timer_regs.sv
module sbd_timer_regs
   import sbd_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [1:0]       idx,
   input  logic [7:0]       wdata,
   output logic [TMR_W-1:0] prescale,
   output logic [TMR_W-1:0] divide,
   output logic             reload
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prescale <= '0;
         divide   <= '0;
         reload   <= 1'b0;
      end else begin
         reload <= we;
         if (we) begin
            case (idx)
               2'd0:    prescale[15:8] <= wdata;
               2'd1:    prescale[7:0]  <= wdata;
               2'd2:    divide[15:8]   <= wdata;
               default: divide[7:0]    <= wdata;
            endcase
         end
      end
   end

endmodule

// File: rtl/sbd_bus_decoder.sv
module sbd_bus_decoder
   import sbd_pkg::*;
#(
   parameter int RAM_AW = 10,
   parameter int VID_AW = 8,
   parameter int AUD_AW = 8,
   parameter int TAG_W  = 4,
   parameter int IN_AW  = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                acc_valid,
   input  logic                acc_write,
   input  logic                acc_word,
   input  logic [IN_AW-1:0]    acc_addr,
   input  logic [7:0]          acc_wdata,
   input  logic [TAG_W-1:0]    acc_tag,
   output logic [N_REGION-1:0] tgt_sel,
   output logic [TAG_W-1:0]    tgt_tag,
   output logic                rd_valid,
   output logic [RSP_W-1:0]    rd_data,
   output logic [TAG_W-1:0]    rd_tag,
   output logic [TMR_W-1:0]    tmr_prescale,
   output logic [TMR_W-1:0]    tmr_divide,
   output logic                tmr_reload
);

   localparam int NLANE = RSP_W / 8;

   if (IN_AW < ADDR_W) begin : g_bad_in_aw
      $error("sbd_bus_decoder: IN_AW must cover 24 address bits");
   end
   if (RAM_AW < 1 || RAM_AW > 22) begin : g_bad_ram_aw
      $error("sbd_bus_decoder: RAM_AW out of range");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("sbd_bus_decoder: TAG_W must be at least 1");
   end

   logic [ADDR_W-1:0] a;
   assign a = acc_addr[ADDR_W-1:0];

   if (IN_AW > ADDR_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^acc_addr[IN_AW-1:ADDR_W];
   end

   // ---------------- decode ----------------
   logic pal_hit, tmr_hit, wave_hit;

   sbd_region_decode #(.NREG(N_REGION)) u_dec (
      .valid    (acc_valid),
      .addr     (a),
      .sel      (tgt_sel),
      .pal_hit  (pal_hit),
      .tmr_hit  (tmr_hit),
      .wave_hit (wave_hit)
   );

   assign tgt_tag = acc_valid ? acc_tag : '0;

   logic wr;
   assign wr = acc_valid && acc_write;

   // ---------------- read lanes (lane 0 = even byte) ----------------
   logic [NLANE-1:0][ADDR_W-1:0] lane_a;
   assign lane_a[0] = acc_word ? {a[ADDR_W-1:1], 1'b0} : a;
   assign lane_a[1] = {a[ADDR_W-1:1], 1'b1};

   logic [NLANE*RAM_AW-1:0] ram_ra;
   logic [NLANE*OPT_AW-1:0] opt_ra;
   logic [NLANE*VID_AW-1:0] vid_ra;
   logic [NLANE*AUD_AW-1:0] aud_ra;
   logic [NLANE*PAL_AW-1:0] pal_ra;

   for (genvar l = 0; l < NLANE; l++) begin : g_ra
      assign ram_ra[l*RAM_AW +: RAM_AW] = lane_a[l][RAM_AW-1:0];
      assign opt_ra[l*OPT_AW +: OPT_AW] = lane_a[l][OPT_AW-1:0];
      assign vid_ra[l*VID_AW +: VID_AW] = lane_a[l][VID_AW-1:0];
      assign aud_ra[l*AUD_AW +: AUD_AW] = lane_a[l][AUD_AW-1:0];
      assign pal_ra[l*PAL_AW +: PAL_AW] = lane_a[l][PAL_AW-1:0];
   end

   // ---------------- storage ----------------
   logic [NLANE*8-1:0]   ram_rd, opt_rd, vid_rd, aud_rd;
   logic [2*NLANE*8-1:0] pal_rd;

   sbd_byte_store #(.AW(RAM_AW), .RP(NLANE)) u_ram (
      .clk   (clk),
      .we    (wr && tgt_sel[RG_RAM]),
      .waddr (a[RAM_AW-1:0]),
      .wdata (acc_wdata),
      .raddr (ram_ra),
      .rdata (ram_rd)
   );

   sbd_byte_store #(.AW(OPT_AW), .RP(NLANE)) u_opt (
      .clk   (clk),
      .we    (wr && tgt_sel[RG_OPT]),
      .waddr (a[OPT_AW-1:0]),
      .wdata (acc_wdata),
      .raddr (opt_ra),
      .rdata (opt_rd)
   );

   sbd_byte_store #(.AW(VID_AW), .RP(NLANE)) u_vid (
      .clk   (clk),
      .we    (wr && tgt_sel[RG_VID] && !pal_hit && !tmr_hit),
      .waddr (a[VID_AW-1:0]),
      .wdata (acc_wdata),
      .raddr (vid_ra),
      .rdata (vid_rd)
   );

   sbd_byte_store #(.AW(AUD_AW), .RP(NLANE)) u_aud (
      .clk   (clk),
      .we    (wr && tgt_sel[RG_AUD] && !wave_hit),
      .waddr (a[AUD_AW-1:0]),
      .wdata (acc_wdata),
      .raddr (aud_ra),
      .rdata (aud_rd)
   );

   // two palette banks, both written by every palette write
   for (genvar b = 0; b < 2; b++) begin : g_pal
      sbd_byte_store #(.AW(PAL_AW), .RP(NLANE)) u_bank (
         .clk   (clk),
         .we    (wr && pal_hit),
         .waddr (a[PAL_AW-1:0]),
         .wdata (acc_wdata),
         .raddr (pal_ra),
         .rdata (pal_rd[b*NLANE*8 +: NLANE*8])
      );
   end

   sbd_timer_regs u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (wr && tmr_hit),
      .idx      (a[1:0]),
      .wdata    (acc_wdata),
      .prescale (tmr_prescale),
      .divide   (tmr_divide),
      .reload   (tmr_reload)
   );

   // ---------------- per-lane read mux ----------------
   logic [NLANE*8-1:0] lane_bytes;

   for (genvar l = 0; l < NLANE; l++) begin : g_lane
      logic [ADDR_W-1:0] la;
      logic [7:0]        lb;
      assign la = lane_a[l];

      always_comb begin
         case (region_of(la))
            RG_RAM:  lb = ram_rd[l*8 +: 8];
            RG_CART: lb = la[7:0] ^ CART_KEY;
            RG_OPT:  lb = opt_rd[l*8 +: 8];
            RG_BOOT: lb = la[7:0] ^ BOOT_KEY;
            RG_VID: begin
               if (is_pal(la)) begin
                  lb = la[PAL_AW] ? pal_rd[NLANE*8 + l*8 +: 8] : pal_rd[l*8 +: 8];
               end else if (is_tmr(la)) begin
                  case (la[1:0])
                     2'd0:    lb = tmr_prescale[15:8];
                     2'd1:    lb = tmr_prescale[7:0];
                     2'd2:    lb = tmr_divide[15:8];
                     default: lb = tmr_divide[7:0];
                  endcase
               end else begin
                  lb = vid_rd[l*8 +: 8];
               end
            end
            RG_AUD:  lb = is_wave(la) ? (la[7:0] ^ WAVE_KEY) : aud_rd[l*8 +: 8];
            default: lb = 8'h00;
         endcase
      end

      assign lane_bytes[l*8 +: 8] = lb;
   end

   // ---------------- read response ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
         rd_tag   <= '0;
      end else begin
         rd_valid <= acc_valid && !acc_write;
         if (acc_valid && !acc_write) begin
            rd_data <= acc_word ? {lane_bytes[7:0], lane_bytes[15:8]}
                                : {8'h00, lane_bytes[7:0]};
            rd_tag  <= acc_tag;
         end
      end
   end

endmodule

// File: rtl/sbd_bus_decoder_chk.sv
module sbd_bus_decoder_chk
   import sbd_pkg::*;
#(
   parameter int TAG_W = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                acc_valid,
   input logic                acc_write,
   input logic [ADDR_W-1:0]   acc_a,
   input logic [TAG_W-1:0]    acc_tag,
   input logic [N_REGION-1:0] tgt_sel,
   input logic                rd_valid,
   input logic [RSP_W-1:0]    rd_data,
   input logic [TAG_W-1:0]    rd_tag,
   input logic [TMR_W-1:0]    tmr_prescale,
   input logic [TMR_W-1:0]    tmr_divide,
   input logic                tmr_reload
);

   logic tmr_wr, gap, low_ram;
   assign tmr_wr  = acc_valid && acc_write && (acc_a >= 24'hF00050) && (acc_a <= 24'hF00053);
   assign gap     = (acc_a >= 24'h400000 && acc_a <= 24'h7FFFFF) ||
                    (acc_a >= 24'hE40000 && acc_a <= 24'hEFFFFF) ||
                    (acc_a >= 24'hF20000);
   assign low_ram = acc_a < 24'h400000;

   // R2
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tgt_sel));

   // R2
   sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (tgt_sel == '0));

   // R2
   sel_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && low_ram) |-> (tgt_sel == {{(N_REGION-1){1'b0}}, 1'b1}));

   // R10
   reload_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_wr |=> tmr_reload);

   // R10
   reload_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tmr_wr |=> !tmr_reload);

   // R9
   tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tmr_wr |=> ($stable(tmr_prescale) && $stable(tmr_divide)));

   // R6
   rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write) |=> (rd_valid && rd_tag == $past(acc_tag)));

   // R5
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write && gap) |=> (rd_data == '0));

endmodule

bind sbd_bus_decoder sbd_bus_decoder_chk #(.TAG_W(TAG_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .acc_valid    (acc_valid),
   .acc_write    (acc_write),
   .acc_a        (acc_addr[23:0]),
   .acc_tag      (acc_tag),
   .tgt_sel      (tgt_sel),
   .rd_valid     (rd_valid),
   .rd_data      (rd_data),
   .rd_tag       (rd_tag),
   .tmr_prescale (tmr_prescale),
   .tmr_divide   (tmr_divide),
   .tmr_reload   (tmr_reload)
);

// File: tb/sbd_bus_decoder_tb.sv
`timescale 1ns/1ps
module sbd_bus_decoder_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0, acc_write = 1'b0, acc_word = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [7:0]  acc_wdata = '0;
   logic [3:0]  acc_tag = '0;
   logic [5:0]  tgt_sel;
   logic [3:0]  tgt_tag, rd_tag;
   logic        rd_valid, tmr_reload;
   logic [15:0] rd_data, tmr_prescale, tmr_divide;

   always #4 clk = ~clk;

   sbd_bus_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_word(acc_word), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
      .acc_tag(acc_tag), .tgt_sel(tgt_sel), .tgt_tag(tgt_tag),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_tag(rd_tag),
      .tmr_prescale(tmr_prescale), .tmr_divide(tmr_divide), .tmr_reload(tmr_reload)
   );

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   logic [7:0]  ram_m [1024];
   logic [7:0]  opt_m [256];
   logic [7:0]  pal_m [512];
   logic [7:0]  vid_m [256];
   logic [7:0]  aud_m [256];
   logic [15:0] pre_m = '0, div_m = '0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // region index per the brief; -1 for unmapped
   function automatic int b_region(input logic [23:0] a);
      if (a < 24'h400000) return 0;
      if (a >= 24'h800000 && a < 24'hDFFF00) return 1;
      if (a >= 24'hDFFF00 && a < 24'hE00000) return 2;
      if (a >= 24'hE00000 && a < 24'hE40000) return 3;
      if (a >= 24'hF00000 && a < 24'hF10000) return 4;
      if (a >= 24'hF10000 && a < 24'hF20000) return 5;
      return -1;
   endfunction

   function automatic bit in_pal(input logic [23:0] a);
      return a >= 24'hF00400 && a <= 24'hF007FF;
   endfunction
   function automatic bit in_tmr(input logic [23:0] a);
      return a >= 24'hF00050 && a <= 24'hF00053;
   endfunction
   function automatic bit in_wave(input logic [23:0] a);
      return a >= 24'hF1D000 && a <= 24'hF1DFFF;
   endfunction

   function automatic logic [7:0] mbyte(input logic [23:0] a);
      case (b_region(a))
         0: return ram_m[a[9:0]];
         1: return a[7:0] ^ 8'hC3;
         2: return opt_m[a[7:0]];
         3: return a[7:0] ^ 8'h5A;
         4: begin
            if (in_pal(a)) return pal_m[a[8:0]];
            if (in_tmr(a)) begin
               case (a[1:0])
                  2'd0: return pre_m[15:8];
                  2'd1: return pre_m[7:0];
                  2'd2: return div_m[15:8];
                  default: return div_m[7:0];
               endcase
            end
            return vid_m[a[7:0]];
         end
         5: return in_wave(a) ? (a[7:0] ^ 8'h96) : aud_m[a[7:0]];
         default: return 8'h00;
      endcase
   endfunction

   task automatic mwrite(input logic [23:0] a, input logic [7:0] d);
      case (b_region(a))
         0: ram_m[a[9:0]] = d;
         2: opt_m[a[7:0]] = d;
         4: begin
            if (in_pal(a)) pal_m[a[8:0]] = d;
            else if (in_tmr(a)) begin
               case (a[1:0])
                  2'd0: pre_m[15:8] = d;
                  2'd1: pre_m[7:0]  = d;
                  2'd2: div_m[15:8] = d;
                  default: div_m[7:0] = d;
               endcase
            end else vid_m[a[7:0]] = d;
         end
         5: if (!in_wave(a)) aud_m[a[7:0]] = d;
         default: ;
      endcase
   endtask

   function automatic string req_of(input logic [23:0] a, input bit word);
      int r;
      if (word) return "R7 word read";
      r = b_region(a);
      if (r == 1 || r == 3) return "R4 ROM read";
      if (r < 0) return "R5 unmapped read";
      if (in_pal(a)) return "R8 palette read";
      if (in_tmr(a)) return "R9 timer read";
      if (in_wave(a)) return "R11 wavetable read";
      return "R3 storage read";
   endfunction

   task automatic access(input bit wr, input bit word, input logic [31:0] addr,
                         input logic [7:0] d, input logic [3:0] tag, input bit check);
      logic [23:0] a;
      logic [15:0] exp_rd;
      int r;
      a = addr[23:0];
      @(negedge clk);
      acc_valid = 1'b1; acc_write = wr; acc_word = word;
      acc_addr = addr; acc_wdata = d; acc_tag = tag;
      #1;
      r = b_region(a);
      if (check) begin
         chk("R2 region select", 32'(tgt_sel), (r < 0) ? 32'h0 : (32'h1 << r));
         chk("R12 tag forward", 32'(tgt_tag), 32'(tag));
      end
      exp_rd = '0;
      if (!wr) begin
         if (word) exp_rd = {mbyte({a[23:1], 1'b0}), mbyte({a[23:1], 1'b1})};
         else      exp_rd = {8'h00, mbyte(a)};
      end else begin
         mwrite(a, d);
      end
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0; acc_word = 1'b0;
      if (check) begin
         if (!wr) begin
            chk("R6 read valid", 32'(rd_valid), 32'h1);
            chk("R6 read tag", 32'(rd_tag), 32'(tag));
            chk(req_of(a, word), 32'(rd_data), 32'(exp_rd));
         end else begin
            chk("R6 no response to write", 32'(rd_valid), 32'h0);
            chk("R10 reload strobe", 32'(tmr_reload), 32'(in_tmr(a)));
            chk("R9 prescale", 32'(tmr_prescale), 32'(pre_m));
            chk("R9 divide", 32'(tmr_divide), 32'(div_m));
         end
      end
   endtask

   function automatic logic [31:0] rand_addr();
      logic [23:0] a;
      case ($urandom_range(0, 11))
         0:  a = 24'($urandom % 32'h400000);
         1:  a = 24'(32'h400000 + $urandom % 32'h400000);
         2:  a = 24'(32'h800000 + $urandom % 32'h5FFF00);
         3:  a = 24'(32'hDFFF00 + $urandom % 32'h100);
         4:  a = 24'(32'hE00000 + $urandom % 32'h40000);
         5:  a = 24'(32'hE40000 + $urandom % 32'hC0000);
         6:  a = 24'(32'hF00000 + $urandom % 32'h10000);
         7:  a = 24'(32'hF00400 + $urandom % 32'h400);
         8:  a = 24'(32'hF00050 + $urandom % 32'h4);
         9:  a = 24'(32'hF10000 + $urandom % 32'h10000);
         10: a = 24'(32'hF1D000 + $urandom % 32'h1000);
         default: a = 24'(32'hF20000 + $urandom % 32'hE0000);
      endcase
      return {8'($urandom), a};
   endfunction

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5BD1C0DE));
      repeat (3) @(negedge clk);
      // R13 reset state
      chk("R13 rd_valid", 32'(rd_valid), 0);
      chk("R13 rd_data", 32'(rd_data), 0);
      chk("R13 rd_tag", 32'(rd_tag), 0);
      chk("R13 prescale", 32'(tmr_prescale), 0);
      chk("R13 divide", 32'(tmr_divide), 0);
      chk("R13 reload", 32'(tmr_reload), 0);
      rst_n = 1'b1;

      // preload every storage byte
      for (int i = 0; i < 1024; i++) access(1, 0, 32'(i), 8'($urandom), 0, 0);
      for (int i = 0; i < 256; i++)  access(1, 0, 32'h00DFFF00 + i, 8'($urandom), 0, 0);
      for (int i = 0; i < 512; i++)  access(1, 0, 32'h00F00400 + i, 8'($urandom), 0, 0);
      for (int i = 0; i < 256; i++)  access(1, 0, 32'h00F00100 + i, 8'($urandom), 0, 0);
      for (int i = 0; i < 256; i++)  access(1, 0, 32'h00F10000 + i, 8'($urandom), 0, 0);

      // R12 idle tag and selects
      @(negedge clk);
      chk("R12 idle tag", 32'(tgt_tag), 0);
      chk("R2 idle select", 32'(tgt_sel), 0);

      // R1 upper bits ignored
      access(1, 0, 32'hA5000123, 8'h3C, 4'h1, 1);
      access(0, 0, 32'h7F000123, 8'h00, 4'h2, 1);
      chk("R1 upper address bits ignored", 32'(rd_data), 32'h003C);

      // R4 cartridge write discarded
      access(1, 0, 32'h00800010, 8'h00, 4'h3, 1);
      access(0, 0, 32'h00800010, 8'h00, 4'h4, 1);
      chk("R4 cartridge keeps pattern", 32'(rd_data), 32'h00D3);

      // R5 hole write discarded, read zero, RAM untouched
      access(1, 0, 32'h00000000, 8'h5E, 4'h5, 1);
      access(1, 0, 32'h00400000, 8'hEE, 4'h6, 1);
      access(0, 0, 32'h00400000, 8'h00, 4'h7, 1);
      chk("R5 hole reads zero", 32'(rd_data), 0);
      access(0, 0, 32'h00000000, 8'h00, 4'h8, 1);
      chk("R5 hole write left RAM alone", 32'(rd_data), 32'h005E);

      // R7 big-endian word at odd address
      access(1, 0, 32'h00000010, 8'hAB, 4'h9, 1);
      access(1, 0, 32'h00000011, 8'hCD, 4'hA, 1);
      access(0, 1, 32'h00000011, 8'h00, 4'hB, 1);
      chk("R7 word order", 32'(rd_data), 32'hABCD);

      // R8 palette mirror both directions
      access(1, 0, 32'h00F00610, 8'h77, 4'h1, 1);
      access(0, 0, 32'h00F00410, 8'h00, 4'h2, 1);
      chk("R8 bank B write seen in bank A", 32'(rd_data), 32'h0077);
      access(1, 0, 32'h00F00420, 8'h88, 4'h3, 1);
      access(0, 0, 32'h00F00620, 8'h00, 4'h4, 1);
      chk("R8 bank A write seen in bank B", 32'(rd_data), 32'h0088);

      // R9 / R10 timer bytes and strobe
      access(1, 0, 32'h00F00050, 8'h12, 4'h5, 1);
      access(1, 0, 32'h00F00051, 8'h34, 4'h6, 1);
      access(1, 0, 32'h00F00052, 8'h56, 4'h7, 1);
      access(1, 0, 32'h00F00053, 8'h78, 4'h8, 1);
      chk("R9 prescale assembled", 32'(tmr_prescale), 32'h1234);
      chk("R9 divide assembled", 32'(tmr_divide), 32'h5678);
      @(negedge clk);
      chk("R10 strobe lasts one clock", 32'(tmr_reload), 0);
      access(0, 1, 32'h00F00052, 8'h00, 4'h9, 1);
      chk("R9 divide readback", 32'(rd_data), 32'h5678);

      // R11 wavetable protected (aliases scratch index 5)
      access(1, 0, 32'h00F10005, 8'h11, 4'hA, 1);
      access(1, 0, 32'h00F1D005, 8'h99, 4'hB, 1);
      access(0, 0, 32'h00F10005, 8'h00, 4'hC, 1);
      chk("R11 wavetable write ignored", 32'(rd_data), 32'h0011);
      access(0, 0, 32'h00F1D005, 8'h00, 4'hD, 1);
      chk("R11 wavetable pattern", 32'(rd_data), 32'h0093);

      // R3 video scratch aliasing
      access(1, 0, 32'h00F00105, 8'h42, 4'hE, 1);
      access(0, 0, 32'h00F00005, 8'h00, 4'hF, 1);
      chk("R3 video scratch alias", 32'(rd_data), 32'h0042);

      // constrained random mix
      for (int n = 0; n < 3000; n++) begin
         access(($urandom % 3) == 0, $urandom % 2, rand_addr(), 8'($urandom), 4'($urandom), 1);
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule